// File: doc/BRIEF.md
# LPC I/O Host Controller

This block lets a host CPU run short bursts of LPC I/O cycles through a small set of memory-mapped registers. Software sets a byte count, a command word (direction and address mode) and a 16-bit target port, and for writes it pushes the outgoing bytes into a byte-wide write queue. It then sets the start bit. The sequencer runs one LPC I/O byte cycle per byte, back to back. It drives the frame strobe and the four LAD lines, releases the bus for the target's turnaround, and follows the target's SYNC codes, including wait states. Bytes read from the target land in a byte-wide read queue, which software drains once the engine is idle again.

Each byte cycle goes through the states START, CTDIR, ADDR, an optional WDATA, TAR_OUT, SYNC, an optional RDATA and TAR_IN. From TAR_IN the engine either loops back to START for the next byte or returns to IDLE. The engine leaves IDLE for START when a start arrives with a valid count. It leaves SYNC for IDLE on an error code or when the wait limit is exceeded, and on a ready code it moves to RDATA (read) or TAR_IN (write). ADDR moves to WDATA (write) or TAR_OUT (read) after its last nibble. The status word has an idle bit and a separate finished bit. Idle with finished clear means the operation failed. The engine runs one LPC clock per `clk` cycle.

Top module: `lpc_io_host`

## Requirements
- R1: After reset the status word reads 1 (bit 0 idle set, bit 1 finished clear), `lpc_frame_n` is high and `lad_oe` is low. While idle the bus stays released with frame high.
- R2: Writing a 1 to bit 0 at offset 0x00 while idle starts the operation. In the next cycle `lpc_frame_n` is low with LAD driven to 0000. Frame is low only in that START cycle of each byte.
- R3: A write byte cycle drives 0010 as cycle type, then the four port nibbles most significant first, then the data byte low nibble first. It then drives 1111 for one turnaround cycle and releases LAD for the second.
- R4: A read byte cycle drives 0000 as cycle type and the four port nibbles. After a ready SYNC it samples two data nibbles, low nibble first, into the read queue (pop at offset 0x28). Bytes come out in cycle order, so the lowest address comes first.
- R5: Offset 0x10 sets the number of byte cycles per start (1 to 4), run without gaps between bytes. A start with count 0 or above 4 ends at once, with status 1 and no frame strobe.
- R6: Command bit 3 set (offset 0x14) keeps every byte at the programmed port (offset 0x20). With bit 3 clear the port advances by one per byte. Command bit 0 selects write (1) or read (0).
- R7: In SYNC the host releases LAD. Code 0000 means ready, and 0101 or 0110 mean wait, which keeps the engine in SYNC.
- R8: Any other SYNC code, such as 1010, ends the operation. The next cycle is idle with finished clear, and the remaining bytes of the burst are dropped.
- R9: Up to 256 consecutive wait codes are accepted in one byte cycle. The 257th ends the operation with finished clear.
- R10: A start written while the engine is busy has no effect on the bus trace, the queues or the status.
- R11: Status bit 0 is clear while busy. Bit 1 is cleared by a start and is set when the last byte completes with a ready SYNC.
- R12: The write queue (push at offset 0x24) is emptied when every operation ends, and the read queue is emptied at every start. Popping an empty queue returns 0, and so does a write byte that was never pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one LPC clock per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the read queue at 0x28) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| lad_in | input | 4 | LAD value driven by the target |
| lad_out | output | 4 | LAD value driven by the host |
| lad_oe | output | 1 | Host drives LAD when high |
| lpc_frame_n | output | 1 | Active-low frame strobe |

## Verification
The first START cycle comes one clock after the edge that takes the start write. Every later bus cycle follows exactly one clock after the one before it. A SYNC code placed on `lad_in` is acted on at the next edge. The bench builds an expected trace of frame, drive enable, LAD and the target's response for every cycle of an operation. It steps through that trace on falling edges, one entry per clock, and checks the quiet idle bus once the trace is used up. Status and queue contents are read combinationally in the first idle cycle after the last trace entry, because that is when the finished bit and the read queue have taken their final values.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_CTDIR,
        ST_ADDR,
        ST_WDATA,
        ST_TAR_OUT,
        ST_SYNC,
        ST_RDATA,
        ST_TAR_IN
    } seq_state_t;

    localparam logic [7:0] OFS_GO     = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [7:0] OFS_COUNT  = 8'h10;
    localparam logic [7:0] OFS_CMD    = 8'h14;
    localparam logic [7:0] OFS_PORT   = 8'h20;
    localparam logic [7:0] OFS_WQ     = 8'h24;
    localparam logic [7:0] OFS_RQ     = 8'h28;

    localparam int CMD_DIR_BIT  = 0;
    localparam int CMD_SAME_BIT = 3;

    localparam logic [3:0] NIB_START   = 4'h0;
    localparam logic [3:0] NIB_CT_RD   = 4'h0;
    localparam logic [3:0] NIB_CT_WR   = 4'h2;
    localparam logic [3:0] NIB_TAR     = 4'hF;
    localparam logic [3:0] SYNC_READY  = 4'h0;
    localparam logic [3:0] SYNC_SWAIT  = 4'h5;
    localparam logic [3:0] SYNC_LWAIT  = 4'h6;

endpackage

// File: rtl/lpc_io_byte_buf.sv
module lpc_io_byte_buf #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [7:0]       mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [LVL_W-1:0] level_q;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (level_q != LVL_W'(DEPTH));
    assign do_pop  = pop && (level_q != '0);
    assign head    = (level_q != '0) ? mem_q[rd_ptr_q] : 8'h00;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (do_push && !do_pop)      level_q <= level_q + LVL_W'(1);
            else if (do_pop && !do_push) level_q <= level_q - LVL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem_q[wr_ptr_q] <= push_data;
    end

endmodule

// File: rtl/lpc_io_wait_timer.sv
module lpc_io_wait_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_limit
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign at_limit = (cnt_q == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (step && !at_limit) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lpc_io_seq.sv
module lpc_io_seq
    import lpc_io_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MAX_BYTES  = 4,
    parameter int WAIT_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [7:0]        count_in,
    input  logic              is_write,
    input  logic              same_port,
    input  logic [ADDR_W-1:0] port_in,
    input  logic [7:0]        wr_byte,
    input  logic [3:0]        lad_in,
    output logic              wr_pop,
    output logic              rd_push,
    output logic [7:0]        rd_byte,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic              frame_n,
    output logic              busy,
    output logic              end_pulse,
    output logic              end_ok,
    output logic              sync_phase
);
    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int NIB_W     = (ADDR_NIBS > 2) ? $clog2(ADDR_NIBS) : 1;
    localparam int CW        = $clog2(MAX_BYTES + 1);

    seq_state_t        state_q, nxt;
    logic [NIB_W-1:0]  nib_q;
    logic [CW-1:0]     total_q;
    logic [CW-1:0]     idx_q;
    logic [ADDR_W-1:0] port_q;
    logic              op_wr_q;
    logic              op_same_q;
    logic [3:0]        lo_nib_q;

    logic count_ok;
    logic nib_last2;
    logic last_byte;
    logic is_wait;
    logic wait_full;
    logic timer_step;
    logic [ADDR_W-1:0] port_shift;

    assign count_ok  = (count_in != 8'h00) && (count_in <= 8'(MAX_BYTES));
    assign nib_last2 = (nib_q == NIB_W'(1));
    assign last_byte = (idx_q == total_q - CW'(1));
    assign is_wait   = (lad_in == SYNC_SWAIT) || (lad_in == SYNC_LWAIT);
    assign busy      = (state_q != ST_IDLE);

    lpc_io_wait_timer #(
        .LIMIT (WAIT_LIMIT)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q != ST_SYNC),
        .step     (timer_step),
        .at_limit (wait_full)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Next state and completion
    always_comb begin
        nxt       = state_q;
        end_pulse = 1'b0;
        end_ok    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (count_ok) nxt = ST_START;
                    else          end_pulse = 1'b1;
                end
            end
            ST_START: nxt = ST_CTDIR;
            ST_CTDIR: nxt = ST_ADDR;
            ST_ADDR: begin
                if (nib_q == NIB_W'(ADDR_NIBS - 1))
                    nxt = op_wr_q ? ST_WDATA : ST_TAR_OUT;
            end
            ST_WDATA:   if (nib_last2) nxt = ST_TAR_OUT;
            ST_TAR_OUT: if (nib_last2) nxt = ST_SYNC;
            ST_SYNC: begin
                if (lad_in == SYNC_READY) begin
                    nxt = op_wr_q ? ST_TAR_IN : ST_RDATA;
                end else if (!is_wait || wait_full) begin
                    nxt       = ST_IDLE;
                    end_pulse = 1'b1;
                end
            end
            ST_RDATA: if (nib_last2) nxt = ST_TAR_IN;
            ST_TAR_IN: begin
                if (nib_last2) begin
                    if (last_byte) begin
                        nxt       = ST_IDLE;
                        end_pulse = 1'b1;
                        end_ok    = 1'b1;
                    end else begin
                        nxt = ST_START;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign port_shift = port_q >> (4 * (ADDR_NIBS - 1 - int'(nib_q)));

    // Bus outputs
    always_comb begin
        frame_n    = 1'b1;
        lad_oe     = 1'b0;
        lad_out    = NIB_TAR;
        wr_pop     = 1'b0;
        rd_push    = 1'b0;
        rd_byte    = {lad_in, lo_nib_q};
        sync_phase = 1'b0;
        timer_step = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_START: begin
                frame_n = 1'b0;
                lad_oe  = 1'b1;
                lad_out = NIB_START;
            end
            ST_CTDIR: begin
                lad_oe  = 1'b1;
                lad_out = op_wr_q ? NIB_CT_WR : NIB_CT_RD;
            end
            ST_ADDR: begin
                lad_oe  = 1'b1;
                lad_out = port_shift[3:0];
            end
            ST_WDATA: begin
                lad_oe  = 1'b1;
                lad_out = nib_last2 ? wr_byte[7:4] : wr_byte[3:0];
                wr_pop  = nib_last2;
            end
            ST_TAR_OUT: begin
                lad_oe  = !nib_last2;
                lad_out = NIB_TAR;
            end
            ST_SYNC: begin
                sync_phase = 1'b1;
                timer_step = is_wait;
            end
            ST_RDATA:  rd_push = nib_last2;
            ST_TAR_IN: ;
            default: ;
        endcase
    end

    // Operation context and nibble counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_q     <= '0;
            total_q   <= '0;
            idx_q     <= '0;
            port_q    <= '0;
            op_wr_q   <= 1'b0;
            op_same_q <= 1'b0;
            lo_nib_q  <= '0;
        end else begin
            if (state_q != nxt) nib_q <= '0;
            else                nib_q <= nib_q + NIB_W'(1);

            if (state_q == ST_IDLE && go && count_ok) begin
                total_q   <= CW'(count_in);
                idx_q     <= '0;
                port_q    <= port_in;
                op_wr_q   <= is_write;
                op_same_q <= same_port;
            end

            if (state_q == ST_TAR_IN && nib_last2 && !last_byte) begin
                idx_q <= idx_q + CW'(1);
                if (!op_same_q) port_q <= port_q + ADDR_W'(1);
            end

            if (state_q == ST_RDATA && !nib_last2) lo_nib_q <= lad_in;
        end
    end

endmodule

// File: rtl/lpc_io_host.sv
module lpc_io_host
    import lpc_io_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MAX_BYTES  = 4,
    parameter int WAIT_LIMIT = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    output logic        lpc_frame_n
);
    logic [7:0]        count_q;
    logic              cmd_wr_q;
    logic              cmd_same_q;
    logic [ADDR_W-1:0] port_q;
    logic              finished_q;

    logic       seq_busy;
    logic       seq_end;
    logic       seq_ok;
    logic       seq_sync;
    logic       start_go;
    logic       wq_pop;
    logic [7:0] wq_head;
    logic       rq_push;
    logic [7:0] rq_byte;
    logic [7:0] rq_head;
    logic       unused_bits;

    assign unused_bits = ^reg_wdata[31:ADDR_W];

    assign start_go = reg_wr && (reg_addr == OFS_GO) && reg_wdata[0] && !seq_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q    <= 8'h00;
            cmd_wr_q   <= 1'b0;
            cmd_same_q <= 1'b0;
            port_q     <= '0;
            finished_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFS_COUNT) count_q <= reg_wdata[7:0];
            if (reg_wr && reg_addr == OFS_CMD) begin
                cmd_wr_q   <= reg_wdata[CMD_DIR_BIT];
                cmd_same_q <= reg_wdata[CMD_SAME_BIT];
            end
            if (reg_wr && reg_addr == OFS_PORT) port_q <= reg_wdata[ADDR_W-1:0];
            if (seq_end)       finished_q <= seq_ok;
            else if (start_go) finished_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_STATUS: reg_rdata = {30'h0, finished_q, !seq_busy};
            OFS_COUNT:  reg_rdata = {24'h0, count_q};
            OFS_CMD:    reg_rdata = 32'(cmd_wr_q) | (32'(cmd_same_q) << CMD_SAME_BIT);
            OFS_PORT:   reg_rdata = 32'(port_q);
            OFS_RQ:     reg_rdata = {24'h0, rq_head};
            default:    reg_rdata = 32'h0;
        endcase
    end

    lpc_io_byte_buf #(
        .DEPTH (MAX_BYTES)
    ) wq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (seq_end),
        .push      (reg_wr && reg_addr == OFS_WQ),
        .push_data (reg_wdata[7:0]),
        .pop       (wq_pop),
        .head      (wq_head)
    );

    lpc_io_byte_buf #(
        .DEPTH (MAX_BYTES)
    ) rq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_go),
        .push      (rq_push),
        .push_data (rq_byte),
        .pop       (reg_rd && reg_addr == OFS_RQ),
        .head      (rq_head)
    );

    lpc_io_seq #(
        .ADDR_W     (ADDR_W),
        .MAX_BYTES  (MAX_BYTES),
        .WAIT_LIMIT (WAIT_LIMIT)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (start_go),
        .count_in   (count_q),
        .is_write   (cmd_wr_q),
        .same_port  (cmd_same_q),
        .port_in    (port_q),
        .wr_byte    (wq_head),
        .lad_in     (lad_in),
        .wr_pop     (wq_pop),
        .rd_push    (rq_push),
        .rd_byte    (rq_byte),
        .lad_out    (lad_out),
        .lad_oe     (lad_oe),
        .frame_n    (lpc_frame_n),
        .busy       (seq_busy),
        .end_pulse  (seq_end),
        .end_ok     (seq_ok),
        .sync_phase (seq_sync)
    );

endmodule

// File: rtl/lpc_io_host_chk.sv
module lpc_io_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic       lad_oe,
    input logic [3:0] lad_out,
    input logic [3:0] lad_in,
    input logic       idle,
    input logic       finished,
    input logic       in_sync
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (frame_n && !lad_oe));

    p_frame_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> (lad_oe && lad_out == 4'h0));

    p_sync_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |-> !lad_oe);

    p_err_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && lad_in == 4'hA) |=> (idle && !finished));

    p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> !finished);

    p_done_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(finished) |-> idle);

endmodule

bind lpc_io_host lpc_io_host_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (lpc_frame_n),
    .lad_oe   (lad_oe),
    .lad_out  (lad_out),
    .lad_in   (lad_in),
    .idle     (!seq_busy),
    .finished (finished_q),
    .in_sync  (seq_sync)
);

// File: tb/lpc_io_host_tb_top.sv
module lpc_io_host_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 256;

    typedef struct packed {
        logic       f;
        logic       oe;
        logic [3:0] lad;
        logic [3:0] din;
    } bus_ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        lpc_frame_n;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bus_ent_t pend_q[$];
    bus_ent_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = !clk;

    lpc_io_host dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .lad_in      (lad_in),
        .lad_out     (lad_out),
        .lad_oe      (lad_oe),
        .lpc_frame_n (lpc_frame_n)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Per-clock reference: one expected bus entry per cycle, idle bus otherwise
    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_q.size() > 0) begin
                bus_ent_t e;
                e = exp_q.pop_front();
                lad_in = e.din;
                chk({lpc_frame_n, lad_oe, lad_oe ? lad_out : 4'h0} == {e.f, e.oe, e.oe ? e.lad : 4'h0},
                    "R2/R3/R4/R7 bus trace", {26'h0, lpc_frame_n, lad_oe, lad_out},
                    {26'h0, e.f, e.oe, e.lad});
            end else begin
                lad_in = 4'hF;
                chk(lpc_frame_n && !lad_oe, "R1 idle bus", {30'h0, lpc_frame_n, lad_oe}, 32'h2);
            end
        end
    end

    task automatic add(input logic f, input logic oe, input logic [3:0] lad, input logic [3:0] din);
        bus_ent_t e;
        e.f = f; e.oe = oe; e.lad = lad; e.din = din;
        pend_q.push_back(e);
    endtask

    // One byte cycle as seen on the bus, target response included
    task automatic build_byte(input bit wr, input logic [15:0] a, input logic [7:0] d,
                              input int nwait, input logic [3:0] fin);
        add(1'b0, 1'b1, 4'h0, 4'hF);
        add(1'b1, 1'b1, wr ? 4'h2 : 4'h0, 4'hF);
        for (int i = 0; i < 4; i++) add(1'b1, 1'b1, a[15 - 4*i -: 4], 4'hF);
        if (wr) begin
            add(1'b1, 1'b1, d[3:0], 4'hF);
            add(1'b1, 1'b1, d[7:4], 4'hF);
        end
        add(1'b1, 1'b1, 4'hF, 4'hF);
        add(1'b1, 1'b0, 4'h0, 4'hF);
        if (nwait > WAIT_LIMIT) begin
            for (int w = 0; w <= WAIT_LIMIT; w++) add(1'b1, 1'b0, 4'h0, w[0] ? 4'h6 : 4'h5);
            return;
        end
        for (int w = 0; w < nwait; w++) add(1'b1, 1'b0, 4'h0, w[0] ? 4'h6 : 4'h5);
        add(1'b1, 1'b0, 4'h0, fin);
        if (fin != 4'h0) return;
        if (!wr) begin
            add(1'b1, 1'b0, 4'h0, d[3:0]);
            add(1'b1, 1'b0, 4'h0, d[7:4]);
        end
        add(1'b1, 1'b0, 4'h0, 4'hF);
        add(1'b1, 1'b0, 4'h0, 4'hF);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic cfg(input logic [7:0] n, input logic [7:0] cmd, input logic [15:0] port);
        reg_write(8'h10, {24'h0, n});
        reg_write(8'h14, {24'h0, cmd});
        reg_write(8'h20, {16'h0, port});
    endtask

    task automatic kick();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h1;
        @(posedge clk);
        exp_q = pend_q;
        pend_q.delete();
        #1 reg_wr = 1'b0;
    endtask

    task automatic wait_end();
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [31:0] exp, input string what);
        logic [31:0] v;
        reg_read(a, v);
        chk(v == exp, what, v, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset state
        expect_read(8'h04, 32'h1, "R1 status after reset");
        chk(lpc_frame_n && !lad_oe, "R1 bus after reset", {30'h0, lpc_frame_n, lad_oe}, 32'h2);

        // R3 / R2: single write byte
        cfg(8'd1, 8'h01, 16'h02F8);
        reg_write(8'h24, 32'hA5);
        build_byte(1'b1, 16'h02F8, 8'hA5, 0, 4'h0);
        kick();
        wait_end();
        expect_read(8'h04, 32'h3, "R11 write done status");

        // R4 / R6: two reads, incrementing port
        cfg(8'd2, 8'h00, 16'h0060);
        build_byte(1'b0, 16'h0060, 8'h34, 2, 4'h0);
        build_byte(1'b0, 16'h0061, 8'h12, 1, 4'h0);
        kick();
        wait_end();
        expect_read(8'h04, 32'h3, "R4 read done status");
        expect_read(8'h28, 32'h34, "R4 first byte low address");
        expect_read(8'h28, 32'h12, "R6 second byte next address");
        expect_read(8'h28, 32'h00, "R12 empty read queue");

        // R6: four reads, fixed port
        cfg(8'd4, 8'h08, 16'h00E4);
        for (int i = 0; i < 4; i++) build_byte(1'b0, 16'h00E4, 8'hC0 + 8'(i), i, 4'h0);
        kick();
        wait_end();
        for (int i = 0; i < 4; i++) expect_read(8'h28, 32'hC0 + i, "R6 fixed port byte");

        // R5 / R7: three writes with waits
        cfg(8'd3, 8'h01, 16'h03FD);
        reg_write(8'h24, 32'h11);
        reg_write(8'h24, 32'h22);
        reg_write(8'h24, 32'h33);
        for (int i = 0; i < 3; i++) build_byte(1'b1, 16'h03FD + 16'(i), 8'h11 * 8'(i + 1), 3, 4'h0);
        kick();
        wait_end();
        expect_read(8'h04, 32'h3, "R5 three byte burst status");

        // R8: error SYNC on first byte drops the rest
        cfg(8'd2, 8'h01, 16'h0080);
        reg_write(8'h24, 32'h5A);
        reg_write(8'h24, 32'h6B);
        build_byte(1'b1, 16'h0080, 8'h5A, 1, 4'hA);
        kick();
        wait_end();
        expect_read(8'h04, 32'h1, "R8 error status");

        // R12: leftover write byte cleared, unpushed byte goes out as zero
        cfg(8'd1, 8'h01, 16'h0081);
        build_byte(1'b1, 16'h0081, 8'h00, 0, 4'h0);
        kick();
        wait_end();
        expect_read(8'h04, 32'h3, "R12 write queue emptied");

        // R10 / R11: start while busy
        cfg(8'd1, 8'h00, 16'h0070);
        build_byte(1'b0, 16'h0070, 8'h77, 10, 4'h0);
        kick();
        repeat (3) @(negedge clk);
        expect_read(8'h04, 32'h0, "R11 busy status");
        reg_write(8'h00, 32'h1);
        wait_end();
        expect_read(8'h04, 32'h3, "R10 status after ignored start");
        expect_read(8'h28, 32'h77, "R10 read byte kept");
        expect_read(8'h28, 32'h00, "R10 no extra byte");

        // R5: invalid counts
        cfg(8'd0, 8'h00, 16'h0070);
        kick();
        expect_read(8'h04, 32'h1, "R5 count zero");
        reg_write(8'h10, 32'h5);
        reg_write(8'h04, 32'h0);
        expect_read(8'h04, 32'h1, "R5 count five still idle");
        kick();
        expect_read(8'h04, 32'h1, "R5 count five");

        // R9: wait limit
        cfg(8'd1, 8'h00, 16'h0090);
        build_byte(1'b0, 16'h0090, 8'h99, WAIT_LIMIT, 4'h0);
        kick();
        wait_end();
        expect_read(8'h04, 32'h3, "R9 256 waits accepted");
        expect_read(8'h28, 32'h99, "R9 byte after long wait");
        build_byte(1'b0, 16'h0090, 8'h00, WAIT_LIMIT + 1, 4'h0);
        kick();
        wait_end();
        expect_read(8'h04, 32'h1, "R9 257th wait fails");

        // R12: read queue emptied at next start
        cfg(8'd2, 8'h08, 16'h00A0);
        build_byte(1'b0, 16'h00A0, 8'h01, 0, 4'h0);
        build_byte(1'b0, 16'h00A0, 8'h02, 0, 4'h0);
        kick();
        wait_end();
        cfg(8'd1, 8'h01, 16'h00A1);
        reg_write(8'h24, 32'h44);
        build_byte(1'b1, 16'h00A1, 8'h44, 0, 4'h0);
        kick();
        wait_end();
        expect_read(8'h28, 32'h00, "R12 read queue cleared by start");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule